// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block collects eight interrupt request lines for a processor and presents them as one interrupt output. Each line passes through a per-line mask and is latched into a request register. The block keeps a record of the lines whose handlers are running. Index 0 has the highest priority and index 7 the lowest. The interrupt output is raised only when a pending, unmasked request outranks every request already in service. The effect is that a handler can be pre-empted only by something more urgent.

The processor acknowledges with a one-cycle `inta` pulse. In that cycle the block drives an 8-bit type number onto `dout`. The upper five bits are a software-set base and the lower three are the winning index. At the clock edge that ends the pulse, the winner moves from the request register into the service register.

Software works through a synchronous register port. It has an active-low select, active-low read and write strobes, one address bit and an 8-bit data bus. A write is taken at each clock edge where both `cs_n` and `wr_n` are low. Through this port software sets the mask, the trigger mode and the vector base, selects which status register is read back, and issues end-of-interrupt commands.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_o` is low and the request, service and mask registers are zero. The vector base is zero, the block is in edge mode, and a status read returns the request register.
- R2: In edge mode, a 0-to-1 change on an unmasked line sets its request bit at that clock edge. A line held high is not captured again after its request has been acknowledged.
- R3: In level mode, each unmasked request bit follows its line level, sampled at each clock edge.
- R4: A write with `a0`=1 and no pending base load sets the mask register to `din`. A masked line is never latched into the request register, and a masked request never raises `int_o`.
- R5: `int_o` is high exactly when the lowest-indexed pending unmasked request has a lower index than the lowest-indexed service bit. An empty service register counts as index 8.
- R6: While `inta` is high and `int_o` is high, `dout` = {base, winning index}. At the edge that ends that cycle, the winner's service bit is set and its request bit is cleared.
- R7: While `inta` is high and `int_o` is low, `dout` = {base, 3'b111}, and the request and service registers are left unchanged.
- R8: A write with `a0`=0 and `din[6:3]`=4'b0100 (non-specific end of interrupt) clears the lowest-indexed set service bit.
- R9: A write with `a0`=0 and `din[6:3]`=4'b1100 (specific end of interrupt) clears the service bit whose index is `din[2:0]`.
- R10: A write with `a0`=0 and `din[4]`=1 (initialisation) sets level mode to `din[3]` and clears the request and service registers, leaving the mask unchanged. The next write with `a0`=1 loads `din[7:3]` into the vector base instead of the mask.
- R11: A write with `a0`=0 and `din[4:3]`=2'b01 sets the read select to `din[0]`. When `cs_n` and `rd_n` are low and `inta` is low, `dout` is the mask if `a0`=1. If `a0`=0, it is the service register when the read select is 1 and the request register when it is 0. Otherwise `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low register select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Status read data or type number |
| irq | input | 8 | Interrupt request lines, index 0 most urgent |
| inta | input | 1 | One-cycle acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bound checker watches several properties on every cycle:
- `int_o` never rises without a pending unmasked request, and stays low while every line is masked.
- A masked line never reaches the request register.
- A granted acknowledge adds exactly one service bit, at the index it reported on `dout`.
- A spurious acknowledge leaves the service register unchanged.

Only the bench's scenarios can show the following: the edge/level capture difference, nested pre-emption order, the two end-of-interrupt forms, the initialisation sequence that redirects one write to the vector base, and the status readback selection. The bench checks these against its behavioural model of `int_o` and `dout`, which it compares on every clock.

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [N-1:0]  irq,
  input  logic          inta,
  output logic          int_o
);
  localparam int IW = $clog2(N);
  localparam int BW = DW - IW;

  function automatic logic [IW:0] lowest(input logic [N-1:0] v);
    lowest = (IW+1)'(N);
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) lowest = (IW+1)'(i);
  endfunction

  logic [N-1:0]  irr_q, isr_q, mask_q, prev_q;
  logic [BW-1:0] base_q;
  logic          level_q, sel_q, armed_q;

  logic [IW:0]   pend_top, isr_top;
  logic [IW-1:0] win;
  logic [N-1:0]  win_bit, capture, eoi_clr;
  logic          ack, wr, rd, cmd_init, cmd_sel, cmd_eoi;

  assign pend_top = lowest(irr_q & ~mask_q);
  assign isr_top  = lowest(isr_q);
  assign int_o    = pend_top < isr_top;
  assign win      = pend_top[IW-1:0];
  assign win_bit  = N'(1) << win;
  assign ack      = inta & int_o;

  assign wr       = ~cs_n & ~wr_n;
  assign rd       = ~cs_n & ~rd_n;
  assign cmd_init = wr & ~a0 & din[4];
  assign cmd_sel  = wr & ~a0 & ~din[4] & din[3];
  assign cmd_eoi  = wr & ~a0 & ~din[4] & ~din[3] & din[5];

  assign capture = level_q ? (irq & ~mask_q)
                           : (irr_q | (irq & ~prev_q & ~mask_q));

  always_comb begin
    eoi_clr = '0;
    if (cmd_eoi) begin
      if (din[6])
        eoi_clr = N'(1) << din[IW-1:0];
      else if (isr_top < (IW+1)'(N))
        eoi_clr = N'(1) << isr_top[IW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q   <= '0;
      isr_q   <= '0;
      mask_q  <= '0;
      prev_q  <= '0;
      base_q  <= '0;
      level_q <= 1'b0;
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= irq;
      if (cmd_init) begin
        level_q <= din[3];
        armed_q <= 1'b1;
        irr_q   <= '0;
        isr_q   <= '0;
      end else begin
        irr_q <= capture & ~(ack ? win_bit : '0);
        isr_q <= (isr_q | (ack ? win_bit : '0)) & ~eoi_clr;
      end
      if (wr && a0) begin
        if (armed_q) begin
          base_q  <= din[DW-1:IW];
          armed_q <= 1'b0;
        end else begin
          mask_q <= din[N-1:0];
        end
      end
      if (cmd_sel) sel_q <= din[0];
    end
  end

  always_comb begin
    if (inta)
      dout = {base_q, int_o ? win : {IW{1'b1}}};
    else if (rd)
      dout = a0 ? DW'(mask_q) : DW'(sel_q ? isr_q : irr_q);
    else
      dout = '0;
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          inta,
  input logic          int_o,
  input logic [DW-1:0] dout,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  mask
);
  localparam int IW = $clog2(N);
  logic quiet_bus;
  assign quiet_bus = cs_n | wr_n;

  p_int_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~mask) != '0));

  p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !int_o);

  p_masked_not_captured_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & $past(mask & ~irr)) == '0));

  p_ack_sets_reported_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && quiet_bus) |=> isr[$past(dout[IW-1:0])]);

  p_ack_adds_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && quiet_bus) |=> ($countones(isr) == $past($countones(isr)) + 1));

  p_spurious_keeps_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_o && quiet_bus) |=> $stable(isr));
endmodule

bind pic_core pic_core_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .inta(inta),
  .int_o(int_o), .dout(dout), .irr(irr_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/sim_pic_core.sv
module sim_pic_core;
  localparam int P = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0, inta = 0;
  logic [7:0] din = 0, irq = 0;
  logic [7:0] dout;
  logic int_o;

  int checks = 0, errors = 0;
  bit done = 0;

  pic_core u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
               .a0(a0), .din(din), .dout(dout), .irq(irq), .inta(inta), .int_o(int_o));

  always #(P/2) clk = ~clk;

  // behavioural reference state
  logic [7:0] m_irr = 0, m_isr = 0, m_mask = 0, m_prev = 0;
  int m_base = 0;
  bit m_level = 0, m_sel = 0, m_armed = 0;

  function automatic int first(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    return first(m_irr & ~m_mask) < first(m_isr);
  endfunction

  function automatic logic [7:0] exp_dout();
    if (inta) return exp_int() ? 8'(m_base * 8 + first(m_irr & ~m_mask)) : 8'(m_base * 8 + 7);
    if (!cs_n && !rd_n) return a0 ? m_mask : (m_sel ? m_isr : m_irr);
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0;
      m_base = 0; m_level = 0; m_sel = 0; m_armed = 0;
    end else begin
      automatic bit granted = exp_int();
      automatic int w = first(m_irr & ~m_mask);
      automatic bit wrt = !cs_n && !wr_n;
      automatic logic [7:0] nirr;
      automatic logic [7:0] nisr = m_isr;
      if (m_level) nirr = irq & ~m_mask;
      else nirr = m_irr | (irq & ~m_prev & ~m_mask);
      if (inta && granted) begin
        nirr[w] = 1'b0;
        nisr[w] = 1'b1;
      end
      if (wrt && !a0 && !din[4] && !din[3] && din[5]) begin
        if (din[6]) nisr[din[2:0]] = 1'b0;
        else if (first(m_isr) < 8) nisr[first(m_isr)] = 1'b0;
      end
      if (wrt && !a0 && din[4]) begin
        m_level = din[3]; nirr = 0; nisr = 0;
      end
      if (wrt && a0) begin
        if (m_armed) m_base = int'(din[7:3]);
        else m_mask = din;
      end
      m_armed = (wrt && !a0 && din[4]) ? 1'b1 : ((wrt && a0) ? 1'b0 : m_armed);
      if (wrt && !a0 && !din[4] && din[3]) m_sel = din[0];
      m_irr = nirr; m_isr = nisr; m_prev = irq;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    #1;
    chk("R5 int_o vs model", {7'd0, int_o}, {7'd0, exp_int()});
    chk("R6/R11 dout vs model", dout, exp_dout());
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic addr, input logic [7:0] d);
    cs_n = 0; wr_n = 0; a0 = addr; din = d;
    tick();
    cs_n = 1; wr_n = 1; a0 = 0; din = 0;
  endtask

  task automatic rd_chk(input logic addr, input logic [7:0] exp, input string tag);
    cs_n = 0; rd_n = 0; a0 = addr;
    #1 chk(tag, dout, exp);
    cs_n = 1; rd_n = 1; a0 = 0;
    #1;
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    inta = 1;
    #1 chk(tag, dout, exp);
    tick();
    inta = 0;
  endtask

  task automatic int_chk(input logic exp, input string tag);
    #1 chk(tag, {7'd0, int_o}, {7'd0, exp});
  endtask

  initial begin
    #(P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tick();
    // R1
    int_chk(0, "R1 int_o after reset");
    rd_chk(0, 8'h00, "R1 request register after reset");
    rd_chk(1, 8'h00, "R1 mask after reset");
    #1 chk("R11 idle dout zero", dout, 8'h00);

    // R2 edge capture
    irq = 8'h08; tick();
    int_chk(1, "R2 rising edge captured");
    rd_chk(0, 8'h08, "R11 request readback");
    ack(8'h03, "R6 vector for line 3");
    tick();
    int_chk(0, "R2 held line not recaptured");
    wr(0, 8'h09);
    rd_chk(0, 8'h08, "R11 service readback");

    // R5 nesting
    irq = 8'h28; tick();
    int_chk(0, "R5 lower priority blocked");
    irq = 8'h2A; tick();
    int_chk(1, "R5 higher priority preempts");
    ack(8'h01, "R6 vector for line 1");
    rd_chk(0, 8'h0A, "R6 two lines in service");
    wr(0, 8'h20);
    rd_chk(0, 8'h08, "R8 non-specific clears lowest index");
    int_chk(0, "R8 line 5 still below line 3");
    wr(0, 8'h63);
    rd_chk(0, 8'h00, "R9 specific clears line 3");
    int_chk(1, "R9 line 5 now raises");
    ack(8'h05, "R6 vector for line 5");
    int_chk(0, "R6 no request left");
    ack(8'h07, "R7 spurious vector");
    rd_chk(0, 8'h20, "R7 service unchanged");

    // R10 init, R3 level
    irq = 8'h00; tick();
    wr(0, 8'h18);
    rd_chk(0, 8'h00, "R10 init clears service");
    wr(1, 8'hA8);
    rd_chk(1, 8'h00, "R10 base write leaves mask");
    irq = 8'h40; tick();
    int_chk(1, "R3 level request seen");
    wr(0, 8'h08);
    rd_chk(0, 8'h40, "R3 request follows line");
    irq = 8'h00; tick();
    int_chk(0, "R3 level request withdrawn");
    rd_chk(0, 8'h00, "R3 request cleared with line");
    irq = 8'h04; tick();
    ack(8'hAA, "R10 vector uses new base");

    // R4 mask
    wr(1, 8'h10);
    rd_chk(1, 8'h10, "R4 mask readback");
    irq = 8'h14; tick();
    rd_chk(0, 8'h04, "R4 masked line not latched");
    int_chk(0, "R5 equal priority blocked");
    irq = 8'h10; tick();
    int_chk(0, "R4 masked line silent");
    rd_chk(0, 8'h00, "R4 request stays empty");
    tick(); tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule